// File: doc/BRIEF.md
# Package Idle-State Resolver

This block merges the idle-state requests of several cores into one package-level idle state. Each core presents a 3-bit encoded request and an enable bit. Disabled cores take no part in the decision. The package goes to the shallowest state that any participating core asks for. The resolved state drives the power controller, which sequences the package into that state.

The block also raises a minimum voltage/frequency request. It does so only when every participating core sits in C1E. The request drops as soon as any one of those cores asks for something else. A global configuration input promotes every plain C1 request to C1E. With it set, cores that halt with C1 can still let the package fall to the low V/f point. Both outputs are registered.

Top module: `pkg_idle_resolver`

## Requirements
- R1: While rst_ni is low, pkg_state_o is 0 (C0) and min_vf_req_o is 0.
- R2: State codes are C0=0, C1=1, C1E=2, C3=3 and C6=4, so a smaller code means a shallower state. pkg_state_o equals the smallest code among enabled cores, one clock after the inputs are sampled.
- R3: A core whose enable bit is 0 has no effect on either output, whatever its request code.
- R4: If no core is enabled, pkg_state_o is C0 and min_vf_req_o is 0.
- R5: When cfg_c1_promote_i is 1, a request of code 1 (C1) counts as code 2 (C1E), both for resolution and for the V/f request.
- R6: min_vf_req_o is 1 exactly when at least one core is enabled and every enabled core requests C1E after promotion. When it is 1, pkg_state_o is C1E.
- R7: If any enabled core requests C0, min_vf_req_o is 0 one clock later.
- R8: Request codes 5 to 7 are not legal and are treated as C0.
- R9: pkg_state_o always holds a legal code, 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_c1_promote_i | input | 1 | Treat every C1 request as C1E |
| core_en_i | input | N_CORES | Per-core participation enable |
| core_req_i | input | N_CORES*3 | Per-core request code; core k uses bits [3k+2:3k] |
| pkg_state_o | output | 3 | Resolved package idle state |
| min_vf_req_o | output | 1 | Request for the minimum V/f operating point |

## Verification
Both outputs come from a single register stage, so each result is due exactly one rising edge after its inputs. The bench changes the inputs on a falling edge and compares the outputs on the following falling edge. Exactly one rising edge falls between the two, so every compare sees the response to the vector under test and nothing older. Wake-up is checked the same way. A vector that pulls one core out of C1E must clear the V/f request at the very next compare.

// File: rtl/pkg_idle_pkg.sv
package pkg_idle_pkg;
  localparam int unsigned ST_W = 3;
  typedef enum logic [ST_W-1:0] {
    ST_C0  = 3'd0,
    ST_C1  = 3'd1,
    ST_C1E = 3'd2,
    ST_C3  = 3'd3,
    ST_C6  = 3'd4
  } idle_st_e;
endpackage

// File: rtl/pkg_idle_norm.sv
module pkg_idle_norm
  import pkg_idle_pkg::*;
(
  input  logic            en_i,
  input  logic            promote_i,
  input  logic [ST_W-1:0] req_i,
  output logic            vote_o,
  output logic [ST_W-1:0] st_o
);
  always_comb begin
    vote_o = en_i;
    unique case (req_i)
      3'd0:    st_o = ST_C0;
      3'd1:    st_o = promote_i ? ST_C1E : ST_C1;
      3'd2:    st_o = ST_C1E;
      3'd3:    st_o = ST_C3;
      3'd4:    st_o = ST_C6;
      default: st_o = ST_C0; // illegal codes wake the package
    endcase
  end
endmodule

// File: rtl/pkg_idle_reduce.sv
module pkg_idle_reduce
  import pkg_idle_pkg::*;
#(
  parameter int unsigned N_CORES = 4
) (
  input  logic [N_CORES-1:0]           vote_i,
  input  logic [N_CORES-1:0][ST_W-1:0] st_i,
  output logic                         any_vote_o,
  output logic                         all_c1e_o,
  output logic [ST_W-1:0]              min_st_o
);
  logic [N_CORES:0][ST_W-1:0] min_c;
  logic [N_CORES:0]           any_c;
  logic [N_CORES:0]           all_c;

  assign min_c[0] = ST_C6;
  assign any_c[0] = 1'b0;
  assign all_c[0] = 1'b1;

  for (genvar i = 0; i < N_CORES; i++) begin : g_chain
    assign min_c[i+1] = (vote_i[i] && (st_i[i] < min_c[i])) ? st_i[i] : min_c[i];
    assign any_c[i+1] = any_c[i] | vote_i[i];
    assign all_c[i+1] = all_c[i] & (!vote_i[i] || (st_i[i] == ST_C1E));
  end

  assign any_vote_o = any_c[N_CORES];
  assign all_c1e_o  = any_c[N_CORES] & all_c[N_CORES];
  assign min_st_o   = any_c[N_CORES] ? min_c[N_CORES] : ST_C0;
endmodule

// File: rtl/pkg_idle_resolver.sv
module pkg_idle_resolver
  import pkg_idle_pkg::*;
#(
  parameter int unsigned N_CORES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_c1_promote_i,
  input  logic [N_CORES-1:0]      core_en_i,
  input  logic [N_CORES*ST_W-1:0] core_req_i,
  output logic [ST_W-1:0]         pkg_state_o,
  output logic                    min_vf_req_o
);
  logic [N_CORES-1:0]           vote;
  logic [N_CORES-1:0][ST_W-1:0] norm_st;
  logic                         any_vote;
  logic                         all_c1e;
  logic [ST_W-1:0]              min_st;
  logic [ST_W-1:0]              state_q;
  logic                         vf_q;

  for (genvar k = 0; k < N_CORES; k++) begin : g_core
    pkg_idle_norm u_norm (
      .en_i      (core_en_i[k]),
      .promote_i (cfg_c1_promote_i),
      .req_i     (core_req_i[k*ST_W +: ST_W]),
      .vote_o    (vote[k]),
      .st_o      (norm_st[k])
    );
  end

  pkg_idle_reduce #(.N_CORES(N_CORES)) u_reduce (
    .vote_i     (vote),
    .st_i       (norm_st),
    .any_vote_o (any_vote),
    .all_c1e_o  (all_c1e),
    .min_st_o   (min_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_C0;
      vf_q    <= 1'b0;
    end else begin
      state_q <= min_st;
      vf_q    <= any_vote & all_c1e;
    end
  end

  assign pkg_state_o  = state_q;
  assign min_vf_req_o = vf_q;

  // checker state: independent wake detection straight from the ports
  logic past_vld_q;
  logic any_wake_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_vld_q <= 1'b0;
    else         past_vld_q <= 1'b1;
  end

  always_comb begin
    any_wake_in = 1'b0;
    for (int k = 0; k < N_CORES; k++) begin
      if (core_en_i[k] && (core_req_i[k*ST_W +: ST_W] == 3'd0 ||
                           core_req_i[k*ST_W +: ST_W] > 3'd4))
        any_wake_in = 1'b1;
    end
  end

  // R9
  legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkg_state_o <= ST_C6);

  // R6
  vf_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_vf_req_o |-> pkg_state_o == ST_C1E);

  // R4
  empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(core_en_i) == '0 |-> pkg_state_o == ST_C0 && !min_vf_req_o);

  // R2 R8
  zero_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(any_wake_in) |-> pkg_state_o == ST_C0);

  // R7
  wake_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_vld_q && $past(any_wake_in) |-> !min_vf_req_o);
endmodule

// File: tb/pkg_idle_resolver_bench.sv
`timescale 1ns/1ps
module pkg_idle_resolver_bench;
  localparam int unsigned N = 4;
  localparam int unsigned W = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           promote = 1'b0;
  logic [N-1:0]   en = '0;
  logic [N*W-1:0] req = '0;
  logic [W-1:0]   st_o;
  logic           vf_o;
  int             n_tests = 0;
  int             n_fail = 0;
  bit             done = 1'b0;

  always #2 clk = ~clk;

  pkg_idle_resolver #(.N_CORES(N)) u_pkg_idle_resolver (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .cfg_c1_promote_i (promote),
    .core_en_i        (en),
    .core_req_i       (req),
    .pkg_state_o      (st_o),
    .min_vf_req_o     (vf_o)
  );

  function automatic logic [W-1:0] norm_code(logic [W-1:0] c, logic p);
    if (c == 3'd1) return p ? 3'd2 : 3'd1;
    if (c > 3'd4)  return 3'd0;
    return c;
  endfunction

  function automatic logic [W-1:0] exp_state(logic [N-1:0] e, logic [N*W-1:0] r, logic p);
    logic [W-1:0] m = 3'd4;
    bit any = 0;
    for (int k = 0; k < N; k++) begin
      if (e[k]) begin
        any = 1;
        if (norm_code(r[k*W +: W], p) < m) m = norm_code(r[k*W +: W], p);
      end
    end
    return any ? m : 3'd0;
  endfunction

  function automatic logic exp_vf(logic [N-1:0] e, logic [N*W-1:0] r, logic p);
    bit any = 0;
    bit all = 1;
    for (int k = 0; k < N; k++) begin
      if (e[k]) begin
        any = 1;
        if (norm_code(r[k*W +: W], p) != 3'd2) all = 0;
      end
    end
    return any && all;
  endfunction

  task automatic chk(string tag, logic [W-1:0] st_exp, logic vf_exp);
    n_tests++;
    if (st_o !== st_exp || vf_o !== vf_exp) begin
      n_fail++;
      $display("FAIL %s: state=%0d exp=%0d vf=%0d exp=%0d", tag, st_o, st_exp, vf_o, vf_exp);
    end
  endtask

  task automatic apply(string tag, logic [N-1:0] e, logic [N*W-1:0] r, logic p);
    @(negedge clk);
    en = e; req = r; promote = p;
    @(negedge clk);
    chk(tag, exp_state(e, r, p), exp_vf(e, r, p));
  endtask

  function automatic logic [N*W-1:0] all_code(logic [W-1:0] c);
    logic [N*W-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = c;
    return v;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: state=%0d exp=done vf=%0d", st_o, vf_o);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] r;
    void'($urandom(32'd1234));
    en  = '1;
    req = all_code(3'd4);
    repeat (3) @(negedge clk);
    chk("R1", 3'd0, 1'b0);
    rst_n = 1'b1;

    apply("R2 all C6", '1, all_code(3'd4), 1'b0);
    r = all_code(3'd4); r[1*W +: W] = 3'd3;
    apply("R2 C3 shallowest", '1, r, 1'b0);
    r[2*W +: W] = 3'd1;
    apply("R2 C1 shallowest", '1, r, 1'b0);
    apply("R4 none enabled", '0, all_code(3'd2), 1'b0);
    r = all_code(3'd2); r[0 +: W] = 3'd0;
    apply("R3 disabled C0 ignored", 4'b1110, r, 1'b0);
    apply("R6 all C1E", '1, all_code(3'd2), 1'b0);
    r = all_code(3'd2); r[3*W +: W] = 3'd0;
    apply("R7 wake drops vf", '1, r, 1'b0);
    apply("R5 promote off", '1, all_code(3'd1), 1'b0);
    apply("R5 promote on", '1, all_code(3'd1), 1'b1);
    r = all_code(3'd2); r[2*W +: W] = 3'd1;
    apply("R5 mixed promoted", '1, r, 1'b1);
    r = all_code(3'd4); r[1*W +: W] = 3'd6;
    apply("R8 illegal code", '1, r, 1'b0);
    r = all_code(3'd2); r[0 +: W] = 3'd3;
    apply("R6 C3 blocks vf", '1, r, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] e = N'($urandom);
      for (int k = 0; k < N; k++)
        r[k*W +: W] = ($urandom % 3 == 0) ? 3'd2 : W'($urandom % 8);
      apply((e == '0) ? "R4 random" : "R2 random", e, r, 1'($urandom));
      if (st_o > 3'd4) begin
        n_tests++; n_fail++;
        $display("FAIL R9: state=%0d exp<=4", st_o);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule